// File: doc/BRIEF.md
# Per-Counter AXI ID Event Qualifier

This block sits beside a bank of performance counters and decides, clock by clock, how much each of three filtered counters should advance. It watches the read address (AR), read data (R), write address (AW) and write data (W) channels of an AXI port. Each channel presents an ID, a valid/ready handshake and, where relevant, a last-beat flag or a burst length and size. Every counter lane has its own event code, its own compare/mask word and its own channel/port word. A lane whose event code selects read-ID or write-ID counting compares the ID of the chosen channel against its masked compare value. It then produces an increment amount: one per burst, or a number of bytes.

Each lane has its own comparator and its own channel selector, so the three counters can follow three unrelated IDs at once. One lane can count bytes while another counts bursts. The counters themselves, and every event source other than this filter, live outside the block. A lane whose event code is not one of the two filter codes reports that it does not own its counter and never produces an increment.

Top module: `axi_id_evt_qual`

## Requirements
- R1: A lane is active only when its 8-bit event code is 0x41 (read-ID counting) or 0x42 (write-ID counting). For any other code, `filt_own` for that lane is low and its increment stays 0. For the two filter codes, `filt_own` is high.
- R2: The compare word of a lane holds the compare ID in bits [15:0] and the mask in bits [31:16]. A transaction ID matches when (ID AND mask) equals (compare ID AND mask), so a mask bit of 1 takes part in the comparison and a mask bit of 0 is ignored.
- R3: Each lane uses only its own event code, compare word, channel word and byte-mode bit. One transaction can therefore produce different increments on different lanes.
- R4: With channel bit [0] of the channel word at 0 (address channel), a lane in burst mode adds 1 for each matching AR (read mode) or AW (write mode) handshake. A cycle with valid high and ready low adds nothing.
- R5: With channel bit [0] at 1 (data channel), a lane in burst mode adds 1 only for a matching R (read mode) or W (write mode) handshake that carries the last-beat flag. Beats that are not last add 0.
- R6: Bits [7:4] of the channel word are the port field. Only port 0 exists, and a lane with a nonzero port field produces no increment.
- R7: In byte mode on the address channel, a matching handshake adds (len+1) shifted left by size, using that channel's 8-bit length and 3-bit size.
- R8: In byte mode on the data channel, every matching data handshake adds BUS_BYTES (8 by default), whether or not it is the last beat.
- R9: A read-mode lane ignores AW and W traffic, and a write-mode lane ignores AR and R traffic, even when the IDs match.
- R10: The increment for a handshake appears on `cnt_inc` in the cycle after the handshake and lasts one cycle. During and right after reset every increment is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_code | input | 24 | Event code per lane, lane n in bits [8n+7:8n] |
| flt_cmp | input | 96 | Compare word per lane (ID [15:0], mask [31:16]), lane n at [32n+31:32n] |
| flt_mux | input | 24 | Channel word per lane (bit 0 channel, bits 7:4 port), lane n at [8n+7:8n] |
| byte_mode | input | 3 | Per lane: 1 adds bytes, 0 counts bursts |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | 16 | Read address ID |
| ar_len | input | 8 | Read burst length minus one |
| ar_size | input | 3 | Read beat size exponent |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | 16 | Read data ID |
| r_last | input | 1 | Last read beat |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | 16 | Write address ID |
| aw_len | input | 8 | Write burst length minus one |
| aw_size | input | 3 | Write beat size exponent |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_id | input | 16 | Write data ID |
| w_last | input | 1 | Last write beat |
| cnt_inc | output | 48 | Increment per lane, lane n at [16n+15:16n] |
| filt_own | output | 3 | Per lane: filter owns this counter |

## Verification
The hardest situation to reach from the ports is a cycle in which all four channels handshake together while three lanes with different modes, masks and channels each pick a different one of them. A fault in how a lane selects its channel only shows up when the wrong channel would also have matched with a different amount. The bench runs a long seeded sweep that sets all four channels' handshakes, IDs from a small ID space, lengths and sizes in every cycle, alongside random per-lane settings, so that masked matches on several channels at once are common. Every lane's increment is checked against an arithmetic model in every cycle.

// File: rtl/axi_qual_pkg.sv
package axi_qual_pkg;

   localparam logic [7:0] EVT_RD_ID = 8'h41;
   localparam logic [7:0] EVT_WR_ID = 8'h42;

   localparam int CHAN_BIT = 0;
   localparam int PORT_LSB = 4;

   typedef enum logic [1:0] {
      QM_OFF = 2'd0,
      QM_RD  = 2'd1,
      QM_WR  = 2'd2
   } qual_mode_e;

   function automatic qual_mode_e mode_of(input logic [7:0] code);
      if (code == EVT_RD_ID)      return QM_RD;
      else if (code == EVT_WR_ID) return QM_WR;
      else                        return QM_OFF;
   endfunction

endpackage

// File: rtl/axi_qual_bytes.sv
module axi_qual_bytes #(
   parameter int LEN_W  = 8,
   parameter int SIZE_W = 3,
   parameter int OUT_W  = 16
) (
   input  logic [LEN_W-1:0]  len_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [OUT_W-1:0]  bytes_o
);
   localparam int MIN_W = LEN_W + (1 << SIZE_W);

   if (OUT_W < MIN_W) begin : g_bad_width
      $error("axi_qual_bytes: OUT_W too narrow for len and size");
   end

   logic [OUT_W-1:0] beats;

   always_comb begin
      beats   = OUT_W'(len_i) + OUT_W'(1);
      bytes_o = beats << size_i;
   end
endmodule

// File: rtl/axi_qual_match.sv
module axi_qual_match #(
   parameter int ID_W = 16
) (
   input  logic [ID_W-1:0] id_i,
   input  logic [ID_W-1:0] cmp_i,
   input  logic [ID_W-1:0] mask_i,
   output logic            hit_o
);
   if (ID_W < 1) begin : g_bad_id
      $error("axi_qual_match: ID_W must be positive");
   end

   assign hit_o = ((id_i ^ cmp_i) & mask_i) == '0;
endmodule

// File: rtl/axi_qual_lane.sv
module axi_qual_lane
   import axi_qual_pkg::*;
#(
   parameter int ID_W      = 16,
   parameter int INC_W     = 16,
   parameter int BUS_BYTES = 8,
   parameter int MUX_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        evt_i,
   input  logic [2*ID_W-1:0] cmp_i,
   input  logic [MUX_W-1:0]  mux_i,
   input  logic              byte_i,
   input  logic              ar_hs,
   input  logic [ID_W-1:0]   ar_id,
   input  logic [INC_W-1:0]  ar_bytes,
   input  logic              r_hs,
   input  logic [ID_W-1:0]   r_id,
   input  logic              r_last,
   input  logic              aw_hs,
   input  logic [ID_W-1:0]   aw_id,
   input  logic [INC_W-1:0]  aw_bytes,
   input  logic              w_hs,
   input  logic [ID_W-1:0]   w_id,
   input  logic              w_last,
   output logic [INC_W-1:0]  inc_o,
   output logic              own_o
);
   localparam int CMP_W = 2 * ID_W;

   if (MUX_W <= PORT_LSB) begin : g_bad_mux
      $error("axi_qual_lane: MUX_W must hold the port field");
   end

   qual_mode_e       mode;
   logic             data_sel;
   logic             port_ok;
   logic [ID_W-1:0]  sel_id;
   logic             sel_hs;
   logic             sel_last;
   logic [INC_W-1:0] sel_bytes;
   logic             hit;
   logic [INC_W-1:0] inc_d;
   logic [INC_W-1:0] inc_q;

   assign mode     = mode_of(evt_i);
   assign data_sel = mux_i[CHAN_BIT];
   assign port_ok  = (mux_i[MUX_W-1:PORT_LSB] == '0);
   assign own_o    = (mode != QM_OFF);

   // Pick one channel first so a single comparator serves the lane
   always_comb begin
      sel_id    = '0;
      sel_hs    = 1'b0;
      sel_last  = 1'b0;
      sel_bytes = '0;
      unique case (mode)
         QM_RD: begin
            sel_id    = data_sel ? r_id : ar_id;
            sel_hs    = data_sel ? r_hs : ar_hs;
            sel_last  = r_last;
            sel_bytes = ar_bytes;
         end
         QM_WR: begin
            sel_id    = data_sel ? w_id : aw_id;
            sel_hs    = data_sel ? w_hs : aw_hs;
            sel_last  = w_last;
            sel_bytes = aw_bytes;
         end
         default: ;
      endcase
   end

   axi_qual_match #(.ID_W(ID_W)) u_match (
      .id_i   (sel_id),
      .cmp_i  (cmp_i[ID_W-1:0]),
      .mask_i (cmp_i[CMP_W-1:ID_W]),
      .hit_o  (hit)
   );

   always_comb begin
      inc_d = '0;
      if (mode != QM_OFF && port_ok && sel_hs && hit) begin
         if (!data_sel)   inc_d = byte_i ? sel_bytes : INC_W'(1);
         else if (byte_i) inc_d = INC_W'(BUS_BYTES);
         else             inc_d = sel_last ? INC_W'(1) : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) inc_q <= '0;
      else        inc_q <= inc_d;
   end

   assign inc_o = inc_q;

   assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o != '0) |-> $past(evt_i == EVT_RD_ID || evt_i == EVT_WR_ID));

   assert_port_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mux_i[MUX_W-1:PORT_LSB] != '0) |-> (inc_o == '0));

   assert_mode_isolation_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evt_i == EVT_RD_ID && !ar_hs && !r_hs) |-> (inc_o == '0));

   assert_burst_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!byte_i) && inc_o != '0) |-> (inc_o == INC_W'(1)));

   assert_data_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(byte_i && mux_i[CHAN_BIT]) && inc_o != '0) |-> (inc_o == INC_W'(BUS_BYTES)));
endmodule

// File: rtl/axi_id_evt_qual.sv
module axi_id_evt_qual
   import axi_qual_pkg::*;
#(
   parameter int NUM_CNT   = 3,
   parameter int ID_W      = 16,
   parameter int LEN_W     = 8,
   parameter int SIZE_W    = 3,
   parameter int EVT_W     = 8,
   parameter int MUX_W     = 8,
   parameter int BUS_BYTES = 8,
   parameter int INC_W     = LEN_W + (1 << SIZE_W)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CNT*EVT_W-1:0]  evt_code,
   input  logic [NUM_CNT*2*ID_W-1:0] flt_cmp,
   input  logic [NUM_CNT*MUX_W-1:0]  flt_mux,
   input  logic [NUM_CNT-1:0]        byte_mode,
   input  logic                      ar_valid,
   input  logic                      ar_ready,
   input  logic [ID_W-1:0]           ar_id,
   input  logic [LEN_W-1:0]          ar_len,
   input  logic [SIZE_W-1:0]         ar_size,
   input  logic                      r_valid,
   input  logic                      r_ready,
   input  logic [ID_W-1:0]           r_id,
   input  logic                      r_last,
   input  logic                      aw_valid,
   input  logic                      aw_ready,
   input  logic [ID_W-1:0]           aw_id,
   input  logic [LEN_W-1:0]          aw_len,
   input  logic [SIZE_W-1:0]         aw_size,
   input  logic                      w_valid,
   input  logic                      w_ready,
   input  logic [ID_W-1:0]           w_id,
   input  logic                      w_last,
   output logic [NUM_CNT*INC_W-1:0]  cnt_inc,
   output logic [NUM_CNT-1:0]        filt_own
);
   localparam int CMP_W = 2 * ID_W;

   if (NUM_CNT < 1) begin : g_bad_cnt
      $error("axi_id_evt_qual: NUM_CNT must be positive");
   end
   if (EVT_W != 8) begin : g_bad_evt
      $error("axi_id_evt_qual: event codes are 8 bits");
   end
   if (BUS_BYTES < 1 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("axi_id_evt_qual: BUS_BYTES must be a power of two");
   end
   if (INC_W < LEN_W + (1 << SIZE_W) || INC_W > 31) begin : g_bad_inc
      $error("axi_id_evt_qual: INC_W out of range");
   end

   logic             ar_hs, r_hs, aw_hs, w_hs;
   logic [INC_W-1:0] ar_bytes, aw_bytes;

   assign ar_hs = ar_valid & ar_ready;
   assign r_hs  = r_valid  & r_ready;
   assign aw_hs = aw_valid & aw_ready;
   assign w_hs  = w_valid  & w_ready;

   // Byte totals are shared by every lane
   axi_qual_bytes #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .OUT_W(INC_W)) u_ar_bytes (
      .len_i (ar_len), .size_i (ar_size), .bytes_o (ar_bytes)
   );
   axi_qual_bytes #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .OUT_W(INC_W)) u_aw_bytes (
      .len_i (aw_len), .size_i (aw_size), .bytes_o (aw_bytes)
   );

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
      axi_qual_lane #(
         .ID_W      (ID_W),
         .INC_W     (INC_W),
         .BUS_BYTES (BUS_BYTES),
         .MUX_W     (MUX_W)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (evt_code[g*EVT_W +: EVT_W]),
         .cmp_i    (flt_cmp[g*CMP_W +: CMP_W]),
         .mux_i    (flt_mux[g*MUX_W +: MUX_W]),
         .byte_i   (byte_mode[g]),
         .ar_hs    (ar_hs),
         .ar_id    (ar_id),
         .ar_bytes (ar_bytes),
         .r_hs     (r_hs),
         .r_id     (r_id),
         .r_last   (r_last),
         .aw_hs    (aw_hs),
         .aw_id    (aw_id),
         .aw_bytes (aw_bytes),
         .w_hs     (w_hs),
         .w_id     (w_id),
         .w_last   (w_last),
         .inc_o    (cnt_inc[g*INC_W +: INC_W]),
         .own_o    (filt_own[g])
      );
   end
endmodule

// File: tb/axi_id_evt_qual_tb.sv
module axi_id_evt_qual_tb_top;
   localparam int NC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [7:0]  evt [NC];
   logic [31:0] cmp [NC];
   logic [7:0]  mux [NC];
   logic        bm  [NC];

   logic [NC*8-1:0]  evt_code;
   logic [NC*32-1:0] flt_cmp;
   logic [NC*8-1:0]  flt_mux;
   logic [NC-1:0]    byte_mode;

   logic arv, arr, rv, rr, rlast, awv, awr, wv, wr, wlast;
   logic [15:0] arid, rid, awid, wid;
   logic [7:0]  arlen, awlen;
   logic [2:0]  arsize, awsize;

   logic [NC*16-1:0] cnt_inc;
   logic [NC-1:0]    filt_own;

   always_comb begin
      for (int i = 0; i < NC; i++) begin
         evt_code[i*8 +: 8]   = evt[i];
         flt_cmp[i*32 +: 32]  = cmp[i];
         flt_mux[i*8 +: 8]    = mux[i];
         byte_mode[i]         = bm[i];
      end
   end

   axi_id_evt_qual dut_i (
      .clk(clk), .rst_n(rst_n),
      .evt_code(evt_code), .flt_cmp(flt_cmp), .flt_mux(flt_mux), .byte_mode(byte_mode),
      .ar_valid(arv), .ar_ready(arr), .ar_id(arid), .ar_len(arlen), .ar_size(arsize),
      .r_valid(rv), .r_ready(rr), .r_id(rid), .r_last(rlast),
      .aw_valid(awv), .aw_ready(awr), .aw_id(awid), .aw_len(awlen), .aw_size(awsize),
      .w_valid(wv), .w_ready(wr), .w_id(wid), .w_last(wlast),
      .cnt_inc(cnt_inc), .filt_own(filt_own)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int unsigned expq [NC];

   task automatic check(input string tag, input int unsigned got, input int unsigned exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   task automatic clr_bus();
      arv = 0; arr = 0; rv = 0; rr = 0; rlast = 0;
      awv = 0; awr = 0; wv = 0; wr = 0; wlast = 0;
      arid = 0; rid = 0; awid = 0; wid = 0;
      arlen = 0; awlen = 0; arsize = 0; awsize = 0;
   endtask

   task automatic clr_cfg();
      for (int i = 0; i < NC; i++) begin
         evt[i] = 8'h00; cmp[i] = 32'h0; mux[i] = 8'h00; bm[i] = 1'b0;
      end
   endtask

   // Expected increment of lane c for the inputs currently applied
   function automatic int unsigned model(input int c);
      logic rd, dat, hs, last, hit;
      logic [15:0] id, m, k;
      int unsigned bytes;
      if (evt[c] == 8'h41)      rd = 1'b1;
      else if (evt[c] == 8'h42) rd = 1'b0;
      else return 0;
      if (mux[c][7:4] != 4'h0) return 0;
      dat = mux[c][0];
      if (rd) begin
         hs = dat ? (rv & rr) : (arv & arr);
         id = dat ? rid : arid;
         last = rlast;
         bytes = (int'(arlen) + 1) * (1 << arsize);
      end else begin
         hs = dat ? (wv & wr) : (awv & awr);
         id = dat ? wid : awid;
         last = wlast;
         bytes = (int'(awlen) + 1) * (1 << awsize);
      end
      m = cmp[c][31:16];
      k = cmp[c][15:0];
      hit = ((id & m) == (k & m));
      if (!hs || !hit) return 0;
      if (!dat) return bm[c] ? bytes : 1;
      if (bm[c]) return 8;
      return last ? 1 : 0;
   endfunction

   function automatic int unsigned got(input int c);
      return int'(cnt_inc[c*16 +: 16]);
   endfunction

   function automatic logic [15:0] small_id();
      logic [15:0] v;
      v = 16'($urandom % 4);
      if ($urandom % 2 == 1) v = v | 16'hA500;
      return v;
   endfunction

   initial begin
      clr_bus();
      clr_cfg();
      repeat (3) @(negedge clk);
      // R10: reset state
      for (int i = 0; i < NC; i++) check("R10 reset inc", got(i), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NC; i++) check("R10 post-reset inc", got(i), 0);

      // R1: ownership over every event code on lane 0
      for (int code = 0; code < 256; code++) begin
         evt[0] = 8'(code);
         #1;
         check("R1 own flag", int'(filt_own[0]), (code == 'h41 || code == 'h42) ? 1 : 0);
      end
      // R1: inactive code with a matching handshake produces nothing
      evt[0] = 8'h40; cmp[0] = 32'h0000_0000;
      arv = 1; arr = 1;
      @(negedge clk);
      check("R1 inactive code", got(0), 0);

      // R4 and R10: one AR handshake, increment for one cycle
      clr_bus(); clr_cfg();
      evt[0] = 8'h41; cmp[0] = 32'hFFFF_1234;
      arv = 1; arr = 1; arid = 16'h1234;
      @(negedge clk);
      check("R10 one cycle later", got(0), 1);
      arv = 0; arr = 0;
      @(negedge clk);
      check("R10 pulse ends", got(0), 0);
      // R4: valid without ready
      arv = 1; arr = 0;
      @(negedge clk);
      check("R4 no ready", got(0), 0);
      clr_bus();

      // R2: masked compare
      cmp[0] = 32'h00F0_00A5;
      arv = 1; arr = 1; arid = 16'h12A7;
      @(negedge clk);
      check("R2 masked match", got(0), 1);
      arid = 16'h00B5;
      @(negedge clk);
      check("R2 masked miss", got(0), 0);
      clr_bus();

      // R3: three lanes, three IDs, one transaction
      for (int i = 0; i < NC; i++) begin
         evt[i] = 8'h41; cmp[i] = {16'hFFFF, 16'(i + 16'h10)};
      end
      arv = 1; arr = 1; arid = 16'h0011;
      @(negedge clk);
      check("R3 lane0", got(0), 0);
      check("R3 lane1", got(1), 1);
      check("R3 lane2", got(2), 0);
      clr_bus(); clr_cfg();

      // R9: mode isolation with matching IDs
      evt[0] = 8'h41; cmp[0] = 32'hFFFF_0007;
      evt[1] = 8'h42; cmp[1] = 32'hFFFF_0007;
      awv = 1; awr = 1; awid = 16'h0007;
      @(negedge clk);
      check("R9 read ignores AW", got(0), 0);
      check("R9 write sees AW", got(1), 1);
      clr_bus();
      arv = 1; arr = 1; arid = 16'h0007;
      @(negedge clk);
      check("R9 write ignores AR", got(1), 0);
      check("R9 read sees AR", got(0), 1);
      clr_bus(); clr_cfg();

      // Random sweep over all channels and lane settings
      for (int t = 0; t < 3000; t++) begin
         for (int i = 0; i < NC; i++) begin
            int unsigned sel;
            sel = $urandom % 4;
            evt[i] = (sel == 0) ? 8'h41 : (sel == 1) ? 8'h42 : (sel == 2) ? 8'h41 : 8'($urandom);
            cmp[i] = {(($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom)), small_id()};
            mux[i] = {(($urandom % 8 == 0) ? 4'(1 + $urandom % 15) : 4'h0), 3'b000, 1'($urandom)};
            bm[i]  = 1'($urandom);
         end
         arv = 1'($urandom); arr = 1'($urandom); arid = small_id();
         arlen = 8'($urandom); arsize = 3'($urandom);
         rv = 1'($urandom); rr = 1'($urandom); rid = small_id(); rlast = 1'($urandom);
         awv = 1'($urandom); awr = 1'($urandom); awid = small_id();
         awlen = 8'($urandom); awsize = 3'($urandom);
         wv = 1'($urandom); wr = 1'($urandom); wid = small_id(); wlast = 1'($urandom);
         #1;
         for (int i = 0; i < NC; i++) expq[i] = model(i);
         @(negedge clk);
         for (int i = 0; i < NC; i++) begin
            if (!(evt[i] == 8'h41 || evt[i] == 8'h42)) check("R1 sweep", got(i), expq[i]);
            else if (mux[i][7:4] != 0)                 check("R6 sweep", got(i), expq[i]);
            else if (!mux[i][0] && bm[i])              check("R7 sweep", got(i), expq[i]);
            else if (!mux[i][0])                       check("R4 sweep", got(i), expq[i]);
            else if (bm[i])                            check("R8 sweep", got(i), expq[i]);
            else                                       check("R5 sweep", got(i), expq[i]);
         end
      end

      // R5 directed: non-last beat adds nothing, last beat adds one
      clr_bus(); clr_cfg();
      evt[2] = 8'h42; cmp[2] = 32'hFFFF_0003; mux[2] = 8'h01;
      wv = 1; wr = 1; wid = 16'h0003; wlast = 0;
      @(negedge clk);
      check("R5 non-last", got(2), 0);
      wlast = 1;
      @(negedge clk);
      check("R5 last", got(2), 1);
      // R8 directed
      bm[2] = 1; wlast = 0;
      @(negedge clk);
      check("R8 beat bytes", got(2), 8);
      // R6 directed
      bm[2] = 0; wlast = 1; mux[2] = 8'h11;
      @(negedge clk);
      check("R6 port nonzero", got(2), 0);
      // R7 directed: len 3, size 2 gives 16 bytes
      clr_bus(); clr_cfg();
      evt[1] = 8'h41; cmp[1] = 32'hFFFF_0009; bm[1] = 1;
      arv = 1; arr = 1; arid = 16'h0009; arlen = 8'd3; arsize = 3'd2;
      @(negedge clk);
      check("R7 bytes", got(1), 16);
      clr_bus();
      @(negedge clk);
      finish_run();
   end
endmodule